// File: doc/BRIEF.md
# Cache-Miss Request Packetizer

This block sits between a pipelined 32-bit processor and an on-chip packet network. When the instruction cache or the data cache misses, the processor presents the miss address together with a read or write enable. The block turns that access into one request packet addressed to a remote memory node and sends it out as a series of flits under a valid/ready handshake.

Three packet kinds exist. An instruction miss on its own yields a packet that carries the missed word address and the three word addresses after it, so that memory can return a prefetch-sized block. A data miss on its own yields a packet that carries the data address, followed by the store word when the access is a write. A data miss and an instruction miss in the same cycle are merged into one packet that carries both.

Returned memory blocks are 128 bits wide and come with separate instruction and data strobes. The block steers each one to the matching processor-side output. While any request is still being sent or still awaits its block, the processor is held off by a low ready.

Top module: `miss_ni_top`

## Requirements
- R1: After reset `req_ready` is 1, and `net_valid`, `ins_vld` and `dat_vld` are 0.
- R2: A request with only `i_rd_en` set at address A is sent as 5 flits: a header with kind 01, count 4 and write bit 0, then A, A+4, A+8 and A+12 (modulo 2^32). `net_flit[33]` marks the first flit and `net_flit[32]` marks the last. Bits [31:0] hold the payload.
- R3: A request with only `d_rd_en` set at address D is sent as a header with kind 10, count 1 and write bit 0, followed by D as the last flit.
- R4: A request with `d_wr_en` set is a store. It is sent as a header with the write bit set and the count raised by 1. The data address comes next, and `d_wdata` is the last flit. A store on its own uses kind 10 and count 2. A store leaves no read pending.
- R5: `i_rd_en` together with a data access in the same accepted cycle gives one packet. Its header has kind 11 and count 5, or count 6 for a store. The body is the four instruction addresses, then the data address, then the store word if there is one.
- R6: While `net_valid` is 1 and `net_ready` is 0, `net_flit` holds its value. The block moves to the next flit only on a cycle where valid and ready are both 1.
- R7: A request is taken only when `req_ready` is 1. `req_ready` stays 0 while a packet is being sent and while any requested block has not yet been delivered. Enables presented while it is 0 are ignored.
- R8: A `mem_i_valid` pulse while an instruction block is pending gives `ins_vld` high for one cycle, on the next cycle, with `ins_blk` equal to `mem_blk`. `mem_d_valid` drives `dat_vld` and `dat_blk` in the same way.
- R9: Strobes that arrive when no block of that kind is pending produce no output valid.
- R10: The header payload carries the memory node ID in bits [31:22], the local node ID in [21:12], the kind in [11:10], the count of following flits in [9:7] and the write bit in [6]. Bits [5:0] are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_miss_addr | input | 32 | Instruction miss address |
| i_rd_en | input | 1 | Instruction read request |
| d_miss_addr | input | 32 | Data miss address |
| d_rd_en | input | 1 | Data read request |
| d_wr_en | input | 1 | Data write request |
| d_wdata | input | 32 | Store data |
| req_ready | output | 1 | Request can be taken; low stalls the processor |
| net_valid | output | 1 | Flit valid toward the network |
| net_ready | input | 1 | Network accepts the flit |
| net_flit | output | 34 | {first, last, payload[31:0]} |
| mem_blk | input | 128 | Block returned by memory |
| mem_i_valid | input | 1 | Returned block is an instruction block |
| mem_d_valid | input | 1 | Returned block is a data block |
| ins_vld | output | 1 | Instruction block valid to the processor |
| ins_blk | output | 128 | Instruction block |
| dat_vld | output | 1 | Data block valid to the processor |
| dat_blk | output | 128 | Data block |

## Verification
The bench sends an instruction miss near the top of the address space so that the prefetch addresses wrap to zero. A design that carried the wrap into upper bits, or stepped by a byte instead of a word, would send wrong body flits. Merged misses are sent both as loads and as stores, which catches a wrong count or a wrong order of the data address and store word inside a kind 11 packet. With ready pulled low at random and held low for long stretches, a design that advanced or changed a flit without a handshake shows up as a lost or altered flit. Requests made during a stall, and strobes sent while nothing is pending, must produce no flits and no valids. A design that leaked them through would emit stray packets or spurious block deliveries.

// File: rtl/miss_ni_pkg.sv
package miss_ni_pkg;
  typedef enum logic [1:0] {
    KIND_NONE = 2'b00,
    KIND_INSN = 2'b01,
    KIND_DATA = 2'b10,
    KIND_BOTH = 2'b11
  } pkt_kind_e;

  typedef struct packed {
    logic has_i;
    logic has_d;
    logic is_wr;
  } req_flags_t;

  localparam int unsigned PREFETCH_WORDS = 4;
  localparam int unsigned IDX_W = 3;
endpackage

// File: rtl/miss_ni_req_capture.sv
module miss_ni_req_capture
  import miss_ni_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          can_take,
  input  logic          i_rd_en,
  input  logic          d_rd_en,
  input  logic          d_wr_en,
  input  logic [AW-1:0] i_addr,
  input  logic [AW-1:0] d_addr,
  input  logic [AW-1:0] wdata,
  output logic          take,
  output pkt_kind_e     kind_q,
  output req_flags_t    flags_q,
  output logic [AW-1:0] ibase_q,
  output logic [AW-1:0] daddr_q,
  output logic [AW-1:0] wdata_q
);
  logic       any_d;
  pkt_kind_e  kind_d;
  req_flags_t flags_d;

  always_comb begin
    any_d         = d_rd_en | d_wr_en;
    take          = can_take & (i_rd_en | any_d);
    flags_d.has_i = i_rd_en;
    flags_d.has_d = any_d;
    flags_d.is_wr = d_wr_en;
    unique case ({i_rd_en, any_d})
      2'b10:   kind_d = KIND_INSN;
      2'b01:   kind_d = KIND_DATA;
      2'b11:   kind_d = KIND_BOTH;
      default: kind_d = KIND_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= KIND_NONE;
      flags_q <= '0;
    end else if (take) begin
      kind_q  <= kind_d;
      flags_q <= flags_d;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      ibase_q <= i_addr;
      daddr_q <= d_addr;
      wdata_q <= wdata;
    end
  end
endmodule

// File: rtl/miss_ni_flit_seq.sv
module miss_ni_flit_seq
  import miss_ni_pkg::*;
#(
  parameter int unsigned          AW     = 32,
  parameter int unsigned          NODE_W = 10,
  parameter logic [NODE_W-1:0]    SRC_ID = 10'd5,
  parameter logic [NODE_W-1:0]    DST_ID = 10'd17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  pkt_kind_e     kind,
  input  req_flags_t    flags,
  input  logic [AW-1:0] ibase,
  input  logic [AW-1:0] daddr,
  input  logic [AW-1:0] wdata,
  input  logic          net_ready,
  output logic          net_valid,
  output logic [AW+1:0] net_flit,
  output logic          busy
);
  localparam int unsigned PAD_W = AW - 2 * NODE_W - 2 - IDX_W - 1;

  logic             busy_q, busy_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] last_idx, d_pos;
  logic [AW-1:0]    offset, payload, header;
  logic             fire, is_head, is_tail;

  always_comb begin
    last_idx = (flags.has_i ? IDX_W'(PREFETCH_WORDS) : '0)
             + (flags.has_d ? IDX_W'(1) : '0)
             + (flags.is_wr ? IDX_W'(1) : '0);
    d_pos    = flags.has_i ? IDX_W'(PREFETCH_WORDS + 1) : IDX_W'(1);
    offset   = AW'(idx_q - IDX_W'(1)) << 2;
    header   = {DST_ID, SRC_ID, kind, last_idx, flags.is_wr, {PAD_W{1'b0}}};
    is_head  = (idx_q == '0);
    is_tail  = (idx_q == last_idx);
    if (is_head)
      payload = header;
    else if (flags.has_i && idx_q <= IDX_W'(PREFETCH_WORDS))
      payload = ibase + offset;
    else if (idx_q == d_pos)
      payload = daddr;
    else
      payload = wdata;
  end

  assign fire      = busy_q & net_ready;
  assign net_valid = busy_q;
  assign net_flit  = {is_head, is_tail, payload};
  assign busy      = busy_q;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    if (start) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (fire) begin
      if (is_tail) begin
        busy_d = 1'b0;
        idx_d  = '0;
      end else begin
        idx_d = idx_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end
endmodule

// File: rtl/miss_ni_rsp_demux.sv
module miss_ni_rsp_demux #(
  parameter int unsigned LINE_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_i,
  input  logic              set_d,
  input  logic [LINE_W-1:0] mem_blk,
  input  logic              mem_i_valid,
  input  logic              mem_d_valid,
  output logic              pend_i,
  output logic              pend_d,
  output logic              ins_vld,
  output logic [LINE_W-1:0] ins_blk,
  output logic              dat_vld,
  output logic [LINE_W-1:0] dat_blk
);
  logic pend_i_q, pend_i_d, pend_d_q, pend_d_d;
  logic hit_i, hit_d;

  always_comb begin
    hit_i    = pend_i_q & mem_i_valid;
    hit_d    = pend_d_q & mem_d_valid;
    pend_i_d = set_i | (pend_i_q & ~hit_i);
    pend_d_d = set_d | (pend_d_q & ~hit_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_i_q <= 1'b0;
      pend_d_q <= 1'b0;
      ins_vld  <= 1'b0;
      dat_vld  <= 1'b0;
    end else begin
      pend_i_q <= pend_i_d;
      pend_d_q <= pend_d_d;
      ins_vld  <= hit_i;
      dat_vld  <= hit_d;
    end
  end

  always_ff @(posedge clk) begin
    if (hit_i) ins_blk <= mem_blk;
    if (hit_d) dat_blk <= mem_blk;
  end

  assign pend_i = pend_i_q;
  assign pend_d = pend_d_q;
endmodule

// File: rtl/miss_ni_top.sv
module miss_ni_top
  import miss_ni_pkg::*;
#(
  parameter int unsigned       AW     = 32,
  parameter int unsigned       LINE_W = 128,
  parameter int unsigned       NODE_W = 10,
  parameter logic [NODE_W-1:0] SRC_ID = 10'd5,
  parameter logic [NODE_W-1:0] DST_ID = 10'd17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     i_miss_addr,
  input  logic              i_rd_en,
  input  logic [AW-1:0]     d_miss_addr,
  input  logic              d_rd_en,
  input  logic              d_wr_en,
  input  logic [AW-1:0]     d_wdata,
  output logic              req_ready,
  output logic              net_valid,
  input  logic              net_ready,
  output logic [AW+1:0]     net_flit,
  input  logic [LINE_W-1:0] mem_blk,
  input  logic              mem_i_valid,
  input  logic              mem_d_valid,
  output logic              ins_vld,
  output logic [LINE_W-1:0] ins_blk,
  output logic              dat_vld,
  output logic [LINE_W-1:0] dat_blk
);
  logic          take, busy, pend_i, pend_d;
  pkt_kind_e     kind_q;
  req_flags_t    flags_q;
  logic [AW-1:0] ibase_q, daddr_q, wdata_q;

  assign req_ready = ~busy & ~pend_i & ~pend_d;

  miss_ni_req_capture #(.AW(AW)) u_cap (
    .clk(clk), .rst_n(rst_n), .can_take(req_ready),
    .i_rd_en(i_rd_en), .d_rd_en(d_rd_en), .d_wr_en(d_wr_en),
    .i_addr(i_miss_addr), .d_addr(d_miss_addr), .wdata(d_wdata),
    .take(take), .kind_q(kind_q), .flags_q(flags_q),
    .ibase_q(ibase_q), .daddr_q(daddr_q), .wdata_q(wdata_q)
  );

  miss_ni_flit_seq #(.AW(AW), .NODE_W(NODE_W), .SRC_ID(SRC_ID), .DST_ID(DST_ID)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(take), .kind(kind_q), .flags(flags_q),
    .ibase(ibase_q), .daddr(daddr_q), .wdata(wdata_q), .net_ready(net_ready),
    .net_valid(net_valid), .net_flit(net_flit), .busy(busy)
  );

  miss_ni_rsp_demux #(.LINE_W(LINE_W)) u_rsp (
    .clk(clk), .rst_n(rst_n),
    .set_i(take & i_rd_en), .set_d(take & d_rd_en & ~d_wr_en),
    .mem_blk(mem_blk), .mem_i_valid(mem_i_valid), .mem_d_valid(mem_d_valid),
    .pend_i(pend_i), .pend_d(pend_d),
    .ins_vld(ins_vld), .ins_blk(ins_blk), .dat_vld(dat_vld), .dat_blk(dat_blk)
  );
endmodule

// File: rtl/miss_ni_chk.sv
module miss_ni_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          net_valid,
  input logic          net_ready,
  input logic [AW+1:0] net_flit,
  input logic          mem_i_valid,
  input logic          mem_d_valid,
  input logic          ins_vld,
  input logic          dat_vld
);
  assert_flit_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (net_valid && !net_ready) |=> (net_valid && $stable(net_flit)));

  assert_stall_while_send_R7: assert property (@(posedge clk) disable iff (!rst_n)
    net_valid |-> !req_ready);

  assert_head_kind_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (net_valid && net_flit[AW+1]) |-> (net_flit[11:10] != 2'b00 && !net_flit[AW]));

  assert_ins_from_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ins_vld |-> $past(mem_i_valid));

  assert_dat_from_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dat_vld |-> $past(mem_d_valid));
endmodule

bind miss_ni_top miss_ni_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .net_valid(net_valid),
  .net_ready(net_ready), .net_flit(net_flit), .mem_i_valid(mem_i_valid),
  .mem_d_valid(mem_d_valid), .ins_vld(ins_vld), .dat_vld(dat_vld)
);

// File: tb/miss_ni_top_tb.sv
module miss_ni_top_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [31:0]  i_miss_addr = '0, d_miss_addr = '0, d_wdata = '0;
  logic         i_rd_en = 1'b0, d_rd_en = 1'b0, d_wr_en = 1'b0;
  logic         req_ready, net_valid, net_ready = 1'b1;
  logic [33:0]  net_flit;
  logic [127:0] mem_blk = '0, ins_blk, dat_blk;
  logic         mem_i_valid = 1'b0, mem_d_valid = 1'b0, ins_vld, dat_vld;

  int unsigned n_checks = 0, n_fail = 0, cycles = 0;
  int          rdy_mode = 0;
  logic [7:0]  lfsr = 8'hA5;
  logic [33:0] exp_q[$];
  string       tag_q[$];
  logic [33:0] prev_flit;
  logic        prev_held = 1'b0;

  miss_ni_top dut_i (.*);

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [33:0] hdr(input logic [1:0] kind, input logic [2:0] cnt, input logic wr);
    return {1'b1, 1'b0, 10'd17, 10'd5, kind, cnt, wr, 6'b0};
  endfunction

  function automatic logic [33:0] body(input logic [31:0] v, input logic last);
    return {1'b0, last, v};
  endfunction

  task automatic issue(input logic ie, input logic [31:0] ia, input logic dr, input logic dw,
                       input logic [31:0] da, input logic [31:0] wd, input string tag);
    logic [2:0] cnt;
    logic       has_d;
    logic [1:0] kind;
    has_d = dr | dw;
    cnt   = (ie ? 3'd4 : 3'd0) + (has_d ? 3'd1 : 3'd0) + (dw ? 3'd1 : 3'd0);
    kind  = {has_d, ie};
    kind  = (ie && has_d) ? 2'b11 : (ie ? 2'b01 : 2'b10);
    exp_q.push_back(hdr(kind, cnt, dw)); tag_q.push_back({tag, " header (R10)"});
    if (ie) begin
      for (int k = 0; k < 4; k++) begin
        exp_q.push_back(body(ia + 32'(4 * k), !has_d && k == 3));
        tag_q.push_back({tag, " insn addr"});
      end
    end
    if (has_d) begin
      exp_q.push_back(body(da, !dw)); tag_q.push_back({tag, " data addr"});
    end
    if (dw) begin
      exp_q.push_back(body(wd, 1'b1)); tag_q.push_back({tag, " store word"});
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    i_rd_en = ie; i_miss_addr = ia; d_rd_en = dr; d_wr_en = dw; d_miss_addr = da; d_wdata = wd;
    @(negedge clk);
    i_rd_en = 1'b0; d_rd_en = 1'b0; d_wr_en = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((exp_q.size() != 0 || net_valid) && guard < 2000) begin
      @(negedge clk); guard++;
    end
    check(exp_q.size() == 0, "R6 all flits delivered", exp_q.size(), 0);
  endtask

  task automatic respond(input bit is_i, input logic [127:0] blk, input string tag);
    @(negedge clk);
    mem_blk = blk;
    if (is_i) mem_i_valid = 1'b1; else mem_d_valid = 1'b1;
    @(negedge clk);
    mem_i_valid = 1'b0; mem_d_valid = 1'b0;
    if (is_i) begin
      check(ins_vld === 1'b1, {tag, " ins_vld"}, ins_vld, 1);
      check(ins_blk === blk, {tag, " ins_blk"}, ins_blk, blk);
    end else begin
      check(dat_vld === 1'b1, {tag, " dat_vld"}, dat_vld, 1);
      check(dat_blk === blk, {tag, " dat_blk"}, dat_blk, blk);
    end
    @(negedge clk);
    check(ins_vld === 1'b0 && dat_vld === 1'b0, {tag, " one-cycle pulse"}, {ins_vld, dat_vld}, 0);
  endtask

  // ready pattern driver
  initial begin
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      case (rdy_mode)
        0: net_ready = 1'b1;
        1: net_ready = lfsr[0];
        default: net_ready = 1'b0;
      endcase
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_held)
        check(net_valid === 1'b1 && net_flit === prev_flit, "R6 flit held while not ready", net_flit, prev_flit);
      if (net_valid && net_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected flit", net_flit, 0);
        end else begin
          logic [33:0] e;
          string       t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          check(net_flit === e, t, net_flit, e);
        end
      end
      prev_held = net_valid && !net_ready;
      prev_flit = net_flit;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready === 1'b1, "R1 req_ready", req_ready, 1);
    check(net_valid === 1'b0, "R1 net_valid", net_valid, 0);
    check(ins_vld === 1'b0 && dat_vld === 1'b0, "R1 block valids", {ins_vld, dat_vld}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready === 1'b1 && net_valid === 1'b0, "R1 idle after release", {req_ready, net_valid}, 2'b10);

    // instruction miss alone
    issue(1, 32'h0000_1000, 0, 0, 0, 0, "R2 insn packet");
    drain();
    check(req_ready === 1'b0, "R7 stall while insn pending", req_ready, 0);
    // request during stall must be ignored
    d_rd_en = 1'b1; d_miss_addr = 32'h5555_0000;
    @(negedge clk); d_rd_en = 1'b0;
    repeat (4) @(negedge clk);
    check(net_valid === 1'b0, "R7 stalled request ignored", net_valid, 0);
    respond(1, 128'h0123_4567_89ab_cdef_0011_2233_4455_6677, "R8 insn block");
    check(req_ready === 1'b1, "R7 ready after delivery", req_ready, 1);
    repeat (3) @(negedge clk);
    check(net_valid === 1'b0, "R7 no late packet from ignored request", net_valid, 0);

    // data read with random backpressure
    rdy_mode = 1;
    issue(0, 0, 1, 0, 32'h2000_0040, 0, "R3 data read packet");
    drain();
    check(req_ready === 1'b0, "R7 stall while data pending", req_ready, 0);
    respond(0, {4{32'hCAFE_0001}}, "R8 data block");

    // store alone
    issue(0, 0, 0, 1, 32'h2000_0080, 32'hDEAD_BEEF, "R4 store packet");
    drain();
    @(negedge clk);
    check(req_ready === 1'b1, "R4 store leaves nothing pending", req_ready, 1);

    // merged miss with address wrap
    issue(1, 32'hFFFF_FFF8, 1, 0, 32'h3000_0000, 0, "R5 merged read packet");
    drain();
    respond(1, {4{32'h1111_2222}}, "R8 merged insn block");
    check(req_ready === 1'b0, "R7 still waiting for data block", req_ready, 0);
    respond(0, {4{32'h3333_4444}}, "R8 merged data block");
    check(req_ready === 1'b1, "R7 ready after both blocks", req_ready, 1);

    // merged miss with store
    issue(1, 32'h0000_0400, 0, 1, 32'h0000_0500, 32'h1234_5678, "R5 merged store packet");
    drain();
    check(req_ready === 1'b0, "R7 insn pending after merged store", req_ready, 0);
    respond(1, {4{32'h5A5A_A5A5}}, "R8 insn after merged store");

    // unsolicited strobes
    @(negedge clk);
    mem_blk = '1; mem_i_valid = 1'b1; mem_d_valid = 1'b1;
    @(negedge clk);
    mem_i_valid = 1'b0; mem_d_valid = 1'b0;
    check(ins_vld === 1'b0 && dat_vld === 1'b0, "R9 unsolicited strobes", {ins_vld, dat_vld}, 0);
    check(req_ready === 1'b1, "R9 ready unaffected", req_ready, 1);

    // long hold with ready low
    rdy_mode = 2;
    issue(0, 0, 1, 0, 32'h7777_0000, 0, "R3 read under hold");
    repeat (6) @(negedge clk);
    check(net_valid === 1'b1 && net_flit === hdr(2'b10, 3'd1, 1'b0), "R6 header held", net_flit, hdr(2'b10, 3'd1, 1'b0));
    rdy_mode = 0;
    drain();
    respond(0, {4{32'h9999_8888}}, "R8 data after hold");

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule